// File: doc/BRIEF.md
# Xon/Xoff Software Flow Controller

This block sits between a serial receiver and its receive buffer. It watches every received byte and compares it against four programmable characters: two that ask the local transmitter to pause (Xoff1, Xoff2) and two that let it resume (Xon1, Xon2). A pause or resume request is either one character, the first of its pair, or two characters that must arrive back to back. A matched request toggles a transmit-hold output and is consumed. Every other byte is passed on to the receive buffer through a registered write strobe.

While the link runs, only the pause characters are matched. While it is held, only the resume characters are matched. A pause match sets a status flag if interrupts are enabled, and a resume match clears that flag. A separate special-character detector raises the same flag whenever a stored byte equals Xoff2. In that case the byte is still written to the buffer. Software clears the flag with an acknowledge pulse.

In two-character mode, a received first character is held back. If the very next byte does not complete the pair, the held byte is written first and the breaking byte one cycle later. For this reason, received bytes must be at least one idle cycle apart. A serial receiver always meets this, because its bytes are many cycles apart.

Top module: `swfc_rx_ctrl`

## Requirements
- R1: After reset, tx_hold_o, flag_o, irq_o and wr_o are all 0.
- R2: With flow_en_i = 0, transmission is never held, and each received byte appears on wr_data_o with wr_o = 1 in the cycle after its rx_valid_i cycle, whatever its value.
- R3: Single mode (dual_i = 0), running: a byte equal to xoff1_i sets tx_hold_o in the next cycle and is not written.
- R4: Single mode, held: a byte equal to xon1_i clears tx_hold_o and flag_o in the next cycle and is not written.
- R5: Two-character mode (dual_i = 1): xoff1_i followed directly by xoff2_i sets tx_hold_o, and xon1_i followed directly by xon2_i clears it. No byte of a completed pair is written. A second character that arrives on its own is stored.
- R6: Two-character mode: when a first character is followed by a byte that does not complete the pair, the held first character is written in the cycle after the breaking byte. The breaking byte is written one cycle later, unless it is itself a first character, in which case it becomes the new held byte.
- R7: A pause match sets flag_o in the same cycle as tx_hold_o only when irq_en_i = 1. irq_o is flag_o AND irq_en_i.
- R8: With spec_en_i = 1, a byte that is written and equals xoff2_i is still written, and it sets flag_o in the same cycle as its wr_o (when irq_en_i = 1).
- R9: An ack_i pulse clears flag_o in the next cycle and leaves tx_hold_o unchanged.
- R10: While running, bytes equal to the resume characters are stored. While held, bytes equal to the pause characters are stored.
- R11: rx_valid_i is never high in two consecutive cycles.
- R12: While held, every byte other than a resume request is still written to the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | DATA_W | Received byte |
| flow_en_i | input | 1 | Software flow control enable |
| dual_i | input | 1 | Two-character sequence mode |
| spec_en_i | input | 1 | Special-character detect enable |
| irq_en_i | input | 1 | Flow-control interrupt enable |
| ack_i | input | 1 | Status acknowledge pulse, clears flag |
| xon1_i | input | DATA_W | First resume character |
| xon2_i | input | DATA_W | Second resume character |
| xoff1_i | input | DATA_W | First pause character |
| xoff2_i | input | DATA_W | Second pause character / special character |
| tx_hold_o | output | 1 | Transmitter suspend request |
| flag_o | output | 1 | Flow-control / special-character status bit |
| irq_o | output | 1 | Interrupt request |
| wr_o | output | 1 | Write strobe to the receive buffer |
| wr_data_o | output | DATA_W | Byte to store |

## Verification
A wrong sequencing state shows up at the ports within one or two cycles of the byte that exposes it. The symptoms are a missing or extra wr_o pulse, a written byte in the wrong order, or tx_hold_o toggling on the wrong character. The bench sweeps every byte value in each of these situations: link running, link held, flow control off, and directly after a held first character. A stuck or mis-held pending byte therefore surfaces as a wrong wr_data_o in the two cycles that follow. Flag faults show up on flag_o and irq_o in the same cycle as the hold change or the write that should have set them.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  typedef enum logic {LINK_RUN = 1'b0, LINK_HOLD = 1'b1} link_e;

  typedef struct packed {
    logic first;
    logic second;
  } hit_t;

  localparam int unsigned N_SEQ = 2;  // 0: pause pair, 1: resume pair
endpackage

// File: rtl/swfc_cmp.sv
module swfc_cmp
  import swfc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] c1_i,
  input  logic [DATA_W-1:0] c2_i,
  output hit_t              hit_o
);
  always_comb begin
    hit_o.first  = (byte_i == c1_i);
    hit_o.second = (byte_i == c2_i);
  end
endmodule

// File: rtl/swfc_seq.sv
module swfc_seq
  import swfc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              flow_en_i,
  input  logic              dual_i,
  input  hit_t              off_hit_i,
  input  hit_t              on_hit_i,
  output logic              hold_o,
  output logic              off_evt_o,
  output logic              on_evt_o,
  output logic              emit_v_o,
  output logic [DATA_W-1:0] emit_data_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  link_e             link_q, link_d;
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] pend_dat_q, pend_dat_d;
  logic              ext_q, ext_d;
  logic [DATA_W-1:0] ext_dat_q, ext_dat_d;
  logic              wr_q;
  logic [DATA_W-1:0] wr_dat_q;
  logic              toggle;
  hit_t              hit;

  always_comb begin
    hit        = (link_q == LINK_HOLD) ? on_hit_i : off_hit_i;
    link_d     = link_q;
    pend_d     = pend_q;
    pend_dat_d = pend_dat_q;
    ext_d      = 1'b0;
    ext_dat_d  = ext_dat_q;
    emit_v_o   = 1'b0;
    emit_data_o = ext_dat_q;
    toggle     = 1'b0;

    // deferred byte from a broken pair
    if (ext_q) begin
      emit_v_o    = 1'b1;
      emit_data_o = ext_dat_q;
    end

    if (rx_valid_i) begin
      if (!flow_en_i) begin
        emit_v_o    = 1'b1;
        emit_data_o = rx_data_i;
        pend_d      = 1'b0;
      end else if (pend_q) begin
        if (dual_i && hit.second) begin
          toggle = 1'b1;
          pend_d = 1'b0;
        end else begin
          emit_v_o    = 1'b1;
          emit_data_o = pend_dat_q;
          if (dual_i && hit.first) begin
            pend_dat_d = rx_data_i;
          end else begin
            pend_d    = 1'b0;
            ext_d     = 1'b1;
            ext_dat_d = rx_data_i;
          end
        end
      end else if (hit.first) begin
        if (dual_i) begin
          pend_d     = 1'b1;
          pend_dat_d = rx_data_i;
        end else begin
          toggle = 1'b1;
        end
      end else begin
        emit_v_o    = 1'b1;
        emit_data_o = rx_data_i;
      end
    end

    if (toggle) link_d = (link_q == LINK_HOLD) ? LINK_RUN : LINK_HOLD;
    if (!flow_en_i) link_d = LINK_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q     <= LINK_RUN;
      pend_q     <= 1'b0;
      pend_dat_q <= '0;
      ext_q      <= 1'b0;
      ext_dat_q  <= '0;
      wr_q       <= 1'b0;
      wr_dat_q   <= '0;
    end else begin
      link_q     <= link_d;
      pend_q     <= pend_d;
      pend_dat_q <= pend_dat_d;
      ext_q      <= ext_d;
      ext_dat_q  <= ext_dat_d;
      wr_q       <= emit_v_o;
      if (emit_v_o) wr_dat_q <= emit_data_o;
    end
  end

  assign hold_o    = (link_q == LINK_HOLD);
  assign off_evt_o = toggle && (link_q == LINK_RUN);
  assign on_evt_o  = toggle && (link_q == LINK_HOLD);
  assign wr_o      = wr_q;
  assign wr_data_o = wr_dat_q;
endmodule

// File: rtl/swfc_stat.sv
module swfc_stat #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              emit_v_i,
  input  logic [DATA_W-1:0] emit_data_i,
  input  logic              spec_en_i,
  input  logic [DATA_W-1:0] spec_chr_i,
  input  logic              irq_en_i,
  input  logic              off_evt_i,
  input  logic              on_evt_i,
  input  logic              ack_i,
  output logic              flag_o
);
  logic flag_q, spec_hit, set_flag;

  assign spec_hit = emit_v_i && spec_en_i && (emit_data_i == spec_chr_i);
  assign set_flag = irq_en_i && (off_evt_i || spec_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (set_flag)          flag_q <= 1'b1;
    else if (on_evt_i || ack_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/swfc_rx_ctrl.sv
module swfc_rx_ctrl
  import swfc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              flow_en_i,
  input  logic              dual_i,
  input  logic              spec_en_i,
  input  logic              irq_en_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] xon1_i,
  input  logic [DATA_W-1:0] xon2_i,
  input  logic [DATA_W-1:0] xoff1_i,
  input  logic [DATA_W-1:0] xoff2_i,
  output logic              tx_hold_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic [DATA_W-1:0] chr1 [N_SEQ];
  logic [DATA_W-1:0] chr2 [N_SEQ];
  hit_t              hit  [N_SEQ];
  logic              off_evt, on_evt, emit_v;
  logic [DATA_W-1:0] emit_data;

  assign chr1[0] = xoff1_i;
  assign chr2[0] = xoff2_i;
  assign chr1[1] = xon1_i;
  assign chr2[1] = xon2_i;

  for (genvar g = 0; g < N_SEQ; g++) begin : g_cmp
    swfc_cmp #(.DATA_W(DATA_W)) u_cmp (
      .byte_i (rx_data_i),
      .c1_i   (chr1[g]),
      .c2_i   (chr2[g]),
      .hit_o  (hit[g])
    );
  end

  swfc_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .flow_en_i   (flow_en_i),
    .dual_i      (dual_i),
    .off_hit_i   (hit[0]),
    .on_hit_i    (hit[1]),
    .hold_o      (tx_hold_o),
    .off_evt_o   (off_evt),
    .on_evt_o    (on_evt),
    .emit_v_o    (emit_v),
    .emit_data_o (emit_data),
    .wr_o        (wr_o),
    .wr_data_o   (wr_data_o)
  );

  swfc_stat #(.DATA_W(DATA_W)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .emit_v_i    (emit_v),
    .emit_data_i (emit_data),
    .spec_en_i   (spec_en_i),
    .spec_chr_i  (xoff2_i),
    .irq_en_i    (irq_en_i),
    .off_evt_i   (off_evt),
    .on_evt_i    (on_evt),
    .ack_i       (ack_i),
    .flag_o      (flag_o)
  );

  assign irq_o = flag_o && irq_en_i;
endmodule

// File: rtl/swfc_rx_ctrl_chk.sv
module swfc_rx_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_valid_i,
  input logic flow_en_i,
  input logic irq_en_i,
  input logic ack_i,
  input logic tx_hold_o,
  input logic flag_o,
  input logic irq_o,
  input logic wr_o
);
  p_no_b2b_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> !rx_valid_i);

  p_flow_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flow_en_i |=> !tx_hold_o);

  p_hold_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_hold_o) |-> (flag_o || !$past(irq_en_i)));

  p_irq_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);

  p_hold_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_hold_o) |-> ($past(rx_valid_i) || !$past(flow_en_i)));

  p_flag_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> ($past(ack_i) || $fell(tx_hold_o)));

  p_wr_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> ($past(rx_valid_i) || $past(wr_o)));
endmodule

bind swfc_rx_ctrl swfc_rx_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_i (rx_valid_i),
  .flow_en_i  (flow_en_i),
  .irq_en_i   (irq_en_i),
  .ack_i      (ack_i),
  .tx_hold_o  (tx_hold_o),
  .flag_o     (flag_o),
  .irq_o      (irq_o),
  .wr_o       (wr_o)
);

// File: tb/swfc_rx_ctrl_bench.sv
`timescale 1ns/1ps
module swfc_rx_ctrl_bench;
  localparam int DW = 8;
  localparam logic [7:0] OFF1 = 8'h13, OFF2 = 8'h93, ON1 = 8'h11, ON2 = 8'h91;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, flow_en = 1'b0, dual = 1'b0, spec_en = 1'b0, irq_en = 1'b0, ack = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic [DW-1:0] xon1 = ON1, xon2 = ON2, xoff1 = OFF1, xoff2 = OFF2;
  logic tx_hold, flag, irq, wr;
  logic [DW-1:0] wr_data;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic w1, w2, h1, f1, f2, i1;
  logic [DW-1:0] d1, d2;

  always #4 clk = ~clk;

  swfc_rx_ctrl #(.DATA_W(DW)) u_swfc_rx_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .flow_en_i(flow_en), .dual_i(dual), .spec_en_i(spec_en), .irq_en_i(irq_en),
    .ack_i(ack), .xon1_i(xon1), .xon2_i(xon2), .xoff1_i(xoff1), .xoff2_i(xoff2),
    .tx_hold_o(tx_hold), .flag_o(flag), .irq_o(irq), .wr_o(wr), .wr_data_o(wr_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [DW-1:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
    w1 = wr; d1 = wr_data; h1 = tx_hold; f1 = flag; i1 = irq;
    @(negedge clk);
    w2 = wr; d2 = wr_data; f2 = flag;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 hold", tx_hold, 0); chk("R1 flag", flag, 0);
    chk("R1 irq", irq, 0);      chk("R1 wr", wr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wr after release", wr, 0);

    // R2: flow control off, all bytes stored
    for (int b = 0; b < 256; b++) begin
      send(8'(b));
      chk("R2 wr", w1, 1); chk("R2 data", d1, b); chk("R2 hold", h1, 0);
    end

    // R3/R4/R10 single mode sweep while running
    flow_en = 1'b1; irq_en = 1'b1;
    for (int b = 0; b < 256; b++) begin
      send(8'(b));
      if (8'(b) == OFF1) begin
        chk("R3 consumed", w1, 0); chk("R3 hold", h1, 1);
        chk("R7 flag", f1, 1);     chk("R7 irq", i1, 1);
        send(ON1);
        chk("R4 consumed", w1, 0); chk("R4 resume", h1, 0); chk("R4 flag clr", f1, 0);
      end else begin
        chk("R10 stored", w1, 1); chk("R10 data", d1, b); chk("R10 hold", h1, 0);
      end
    end

    // R12/R10 sweep while held
    send(OFF1);
    chk("R3 hold", h1, 1);
    for (int b = 0; b < 256; b++) begin
      if (8'(b) == ON1) continue;
      send(8'(b));
      chk("R12 stored", w1, 1); chk("R12 data", d1, b); chk("R12 held", h1, 1);
    end
    send(ON1);
    chk("R4 resume", h1, 0);

    // R7: interrupt disabled
    irq_en = 1'b0;
    send(OFF1);
    chk("R7 hold", h1, 1); chk("R7 no flag", f1, 0); chk("R7 no irq", i1, 0);
    send(ON1);
    chk("R4 resume", h1, 0);

    // R9: ack clears flag, hold stays
    irq_en = 1'b1;
    send(OFF1);
    chk("R9 flag set", f1, 1);
    pulse_ack();
    @(negedge clk);
    chk("R9 flag clr", flag, 0); chk("R9 hold kept", tx_hold, 1);
    send(ON1);
    chk("R4 resume", h1, 0);

    // R5/R6 two-character mode sweep of the byte after a first character
    dual = 1'b1;
    send(OFF2);
    chk("R5 lone second stored", w1, 1); chk("R5 lone data", d1, OFF2); chk("R5 no hold", h1, 0);
    for (int b = 0; b < 256; b++) begin
      send(OFF1);
      chk("R6 first held", w1, 0);
      send(8'(b));
      if (8'(b) == OFF2) begin
        chk("R5 pair w1", w1, 0); chk("R5 pair w2", w2, 0); chk("R5 pair hold", h1, 1);
        send(ON1);
        chk("R5 on first", w1, 0); chk("R5 still held", h1, 1);
        send(ON2);
        chk("R5 on w1", w1, 0); chk("R5 on w2", w2, 0); chk("R5 resume", h1, 0);
      end else if (8'(b) == OFF1) begin
        chk("R6 old out", w1, 1); chk("R6 old data", d1, OFF1); chk("R6 new held", w2, 0);
        send(8'h00);
        chk("R6 flush w1", w1, 1); chk("R6 flush d1", d1, OFF1);
        chk("R6 flush w2", w2, 1); chk("R6 flush d2", d2, 0);
      end else begin
        chk("R6 w1", w1, 1); chk("R6 d1", d1, OFF1);
        chk("R6 w2", w2, 1); chk("R6 d2", d2, b); chk("R6 hold", h1, 0);
      end
    end

    // R8: special character kept and flagged
    dual = 1'b0; spec_en = 1'b1;
    pulse_ack();
    send(OFF2);
    chk("R8 stored", w1, 1); chk("R8 data", d1, OFF2);
    chk("R8 flag", f1, 1);   chk("R8 no hold", h1, 0);
    pulse_ack();
    irq_en = 1'b0;
    send(OFF2);
    chk("R8 stored no irq", w1, 1); chk("R8 no flag", f1, 0);
    send(8'h42);
    chk("R8 other no flag", f1, 0);

    // R2: disabling flow control releases hold
    irq_en = 1'b1; spec_en = 1'b0;
    send(OFF1);
    chk("R3 hold", h1, 1);
    @(negedge clk); flow_en = 1'b0;
    @(negedge clk);
    chk("R2 release", tx_hold, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule